// File: doc/BRIEF.md
# Address Tenure Timeout Watchdog

This block watches the address phase of a split-transaction bus, where each transfer has an address tenure followed by a separate data tenure. When a master opens an address tenure, the watchdog loads a cycle budget taken from a period input. If no slave acknowledges the address within that budget, the watchdog closes the stalled tenure itself. It then opens a substitute data tenure and closes that tenure with a one-cycle transfer-error pulse. The bus therefore always comes back to idle and is never left hung.

Each tenure carries a transfer-type code, and some codes are reserved. A tenure that opens with a reserved code goes through the same forced close and failed data tenure at once, without waiting. Both kinds of failure set their own sticky error bit, and both bits drive a single interrupt line. The identity of the first failing tenure is held for software: its master ID and its transfer type. A host write that sets a bit position to one clears the matching error bit.

Top module: `addr_tenure_watchdog`

## Requirements
- R1: After reset, all pulse outputs, both sticky error bits and the interrupt are low.
- R2: Let cycle 0 be the cycle in which a non-reserved start is sampled with period P > 0. If `ten_ack` is not sampled in any of cycles 1..P, then `force_aend` is high in cycle P+1.
- R3: If `ten_ack` is high in any of cycles 1..P, no forced pulse and no transfer error follow for that tenure. This includes an acknowledge in cycle P itself.
- R4: A forced sequence is `force_aend`, then `force_dstart`, then `xfer_err`, each high for exactly one cycle in consecutive cycles. At most one of the three is high at a time, and the block is idle in the cycle after `xfer_err`.
- R5: A non-reserved start with `timeout_cycles` equal to 0 never times out.
- R6: A new start sampled while a tenure is being timed restarts the count from zero with the newly presented period.
- R7: `err_timeout` is set in cycle P+1 of a timeout and stays set until a host write with `host_wdata[0]` equal to 1.
- R8: Transfer type t is reserved when bit t of `RSV_MASK` is 1; by default this is codes 8, 30 and 31. A reserved start in cycle 0 gives `force_aend` in cycle 1, `force_dstart` in cycle 2, `xfer_err` in cycle 3, and sets `err_rsv_type` from cycle 1. Only a host write with `host_wdata[1]` equal to 1 clears `err_rsv_type`.
- R9: `err_mid` and `err_ttype` capture the master ID and transfer type of a failing tenure only when both sticky bits are clear. Otherwise they hold.
- R10: `err_irq` is high exactly when at least one sticky error bit is set.
- R11: A start sampled while a forced sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ten_start | input | 1 | Address tenure opens this cycle |
| ten_mid | input | MID_W | Master ID of the opening tenure |
| ten_ttype | input | TT_W | Transfer-type code of the opening tenure |
| ten_ack | input | 1 | Slave acknowledges the current address tenure |
| timeout_cycles | input | CNT_W | Cycle budget, sampled at start; 0 disables |
| host_wr | input | 1 | Host write strobe for the error bits |
| host_wdata | input | 2 | Write-one-to-clear: bit 0 timeout, bit 1 reserved type |
| force_aend | output | 1 | Forced end of the address tenure |
| force_dstart | output | 1 | Start of the substitute data tenure |
| xfer_err | output | 1 | Transfer error ending the substitute data tenure |
| err_timeout | output | 1 | Sticky address-timeout bit |
| err_rsv_type | output | 1 | Sticky reserved-type bit |
| err_mid | output | MID_W | Master ID of the first recorded failure |
| err_ttype | output | TT_W | Transfer type of the first recorded failure |
| err_irq | output | 1 | Error interrupt |

## Verification
Each result falls on a fixed cycle. With the start in cycle 0, a timeout produces its three pulses in cycles P+1, P+2 and P+3. A reserved type produces them in cycles 1, 2 and 3, and the sticky bits appear in the first cycle of the forced sequence. The driver counts cycles from the start and pushes one expected pulse triple for every cycle it drives. The monitor pops one triple per cycle at the falling edge and compares it with the three pulse outputs, so any pulse that arrives one cycle early or late is caught. Status outputs are read at a falling edge once the sequence has ended, and one idle cycle follows each forced sequence so that a missing return to idle shows up.

// File: rtl/atw_pkg.sv
package atw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_FEND  = 3'd2,
      ST_FDATA = 3'd3,
      ST_TERR  = 3'd4
   } atw_state_e;

   localparam int unsigned ERR_BIT_TO  = 0;
   localparam int unsigned ERR_BIT_RSV = 1;
endpackage

// File: rtl/atw_rsv_decode.sv
module atw_rsv_decode #(
   parameter int unsigned TT_W = 5,
   parameter logic [2**TT_W-1:0] RSV_MASK = '0
) (
   input  logic [TT_W-1:0] ttype,
   output logic            hit
);
   localparam int unsigned NCODE = 2**TT_W;

   generate
      if (RSV_MASK == '0) begin : g_none
         assign hit = 1'b0;
      end else begin : g_lookup
         logic [NCODE-1:0] match;
         for (genvar i = 0; i < NCODE; i++) begin : g_code
            assign match[i] = RSV_MASK[i] && (ttype == TT_W'(i));
         end
         assign hit = |match;
      end
   endgenerate
endmodule

// File: rtl/atw_cycle_timer.sv
module atw_cycle_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] period_in,
   input  logic             run,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] per;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         per <= '0;
      end else if (load) begin
         cnt <= '0;
         per <= period_in;
      end else if (run) begin
         cnt <= cnt + ONE;
      end
   end

   assign expire = (per != '0) && (cnt == per - ONE);

   // a running count never reaches the loaded period
   assert_cnt_below_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (per != '0) |-> (cnt < per));
   // a zero period never lets the timer run
   assert_no_run_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (per != '0));
endmodule

// File: rtl/atw_err_log.sv
module atw_err_log #(
   parameter int unsigned MID_W = 4,
   parameter int unsigned TT_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_to,
   input  logic             set_rsv,
   input  logic [MID_W-1:0] mid_in,
   input  logic [TT_W-1:0]  tt_in,
   input  logic             clr_wr,
   input  logic [1:0]       clr_bits,
   output logic             to_flag,
   output logic             rsv_flag,
   output logic [MID_W-1:0] mid_q,
   output logic [TT_W-1:0]  tt_q
);
   import atw_pkg::*;

   logic clr_to, clr_rsv, capture;

   assign clr_to  = clr_wr && clr_bits[ERR_BIT_TO];
   assign clr_rsv = clr_wr && clr_bits[ERR_BIT_RSV];
   assign capture = (set_to || set_rsv) && !to_flag && !rsv_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_flag  <= 1'b0;
         rsv_flag <= 1'b0;
         mid_q    <= '0;
         tt_q     <= '0;
      end else begin
         to_flag  <= set_to  || (to_flag  && !clr_to);
         rsv_flag <= set_rsv || (rsv_flag && !clr_rsv);
         if (capture) begin
            mid_q <= mid_in;
            tt_q  <= tt_in;
         end
      end
   end

   assert_to_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && !clr_to) |=> to_flag);
   assert_rsv_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsv_flag && !clr_rsv) |=> rsv_flag);
   assert_capture_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag || rsv_flag) |=> ($stable(mid_q) && $stable(tt_q)));
endmodule

// File: rtl/addr_tenure_watchdog.sv
module addr_tenure_watchdog #(
   parameter int unsigned MID_W = 4,
   parameter int unsigned TT_W  = 5,
   parameter int unsigned CNT_W = 16,
   parameter logic [2**TT_W-1:0] RSV_MASK = (2**TT_W)'(32'hC000_0100)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ten_start,
   input  logic [MID_W-1:0] ten_mid,
   input  logic [TT_W-1:0]  ten_ttype,
   input  logic             ten_ack,
   input  logic [CNT_W-1:0] timeout_cycles,
   input  logic             host_wr,
   input  logic [1:0]       host_wdata,
   output logic             force_aend,
   output logic             force_dstart,
   output logic             xfer_err,
   output logic             err_timeout,
   output logic             err_rsv_type,
   output logic [MID_W-1:0] err_mid,
   output logic [TT_W-1:0]  err_ttype,
   output logic             err_irq
);
   import atw_pkg::*;

   generate
      if (MID_W < 1 || MID_W > 16) begin : g_bad_mid
         $error("MID_W must lie in 1..16");
      end
      if (TT_W < 1 || TT_W > 6) begin : g_bad_tt
         $error("TT_W must lie in 1..6");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
   endgenerate

   atw_state_e       st, st_nxt;
   logic             rsv_hit, tmr_load, tmr_run, tmr_expire;
   logic             set_to, set_rsv, cap_cur, can_start;
   logic [MID_W-1:0] cur_mid, log_mid;
   logic [TT_W-1:0]  cur_tt, log_tt;

   atw_rsv_decode #(.TT_W(TT_W), .RSV_MASK(RSV_MASK)) u_rsv (
      .ttype (ten_ttype),
      .hit   (rsv_hit)
   );

   atw_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tmr_load),
      .period_in (timeout_cycles),
      .run       (tmr_run),
      .expire    (tmr_expire)
   );

   assign can_start = (st == ST_IDLE) || (st == ST_WAIT);

   always_comb begin
      st_nxt   = st;
      tmr_load = 1'b0;
      set_to   = 1'b0;
      set_rsv  = 1'b0;
      cap_cur  = 1'b0;
      if (can_start && ten_start) begin
         cap_cur = 1'b1;
         if (rsv_hit) begin
            st_nxt  = ST_FEND;
            set_rsv = 1'b1;
         end else if (timeout_cycles == '0) begin
            st_nxt = ST_IDLE;
         end else begin
            st_nxt   = ST_WAIT;
            tmr_load = 1'b1;
         end
      end else begin
         case (st)
            ST_WAIT: begin
               if (ten_ack) begin
                  st_nxt = ST_IDLE;
               end else if (tmr_expire) begin
                  st_nxt = ST_FEND;
                  set_to = 1'b1;
               end
            end
            ST_FEND:  st_nxt = ST_FDATA;
            ST_FDATA: st_nxt = ST_TERR;
            ST_TERR:  st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
         endcase
      end
   end

   assign tmr_run = (st == ST_WAIT) && !ten_start && !ten_ack && !tmr_expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur_mid <= '0;
         cur_tt  <= '0;
      end else begin
         st <= st_nxt;
         if (cap_cur) begin
            cur_mid <= ten_mid;
            cur_tt  <= ten_ttype;
         end
      end
   end

   assign log_mid = set_rsv ? ten_mid   : cur_mid;
   assign log_tt  = set_rsv ? ten_ttype : cur_tt;

   atw_err_log #(.MID_W(MID_W), .TT_W(TT_W)) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_to   (set_to),
      .set_rsv  (set_rsv),
      .mid_in   (log_mid),
      .tt_in    (log_tt),
      .clr_wr   (host_wr),
      .clr_bits (host_wdata),
      .to_flag  (err_timeout),
      .rsv_flag (err_rsv_type),
      .mid_q    (err_mid),
      .tt_q     (err_ttype)
   );

   assign force_aend   = (st == ST_FEND);
   assign force_dstart = (st == ST_FDATA);
   assign xfer_err     = (st == ST_TERR);
   assign err_irq      = err_timeout || err_rsv_type;

   assert_fend_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      force_aend |=> (force_dstart && !force_aend));
   assert_data_then_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      force_dstart |=> (xfer_err && !force_dstart));
   assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |=> (!xfer_err && !force_aend && !force_dstart));
   assert_pulse_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({force_aend, force_dstart, xfer_err}));
   assert_rsv_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (can_start && ten_start && rsv_hit) |=> (force_aend && err_rsv_type));
   assert_zero_period_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (can_start && ten_start && !rsv_hit && timeout_cycles == '0) |=> !force_aend);
   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (force_aend && ten_start) |=> force_dstart);
   assert_timeout_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(force_aend) && !err_rsv_type |-> err_timeout);
endmodule

// File: tb/sim_addr_tenure_watchdog.sv
module sim_addr_tenure_watchdog;
   typedef struct {
      logic [2:0] exp;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ten_start = 1'b0;
   logic [3:0]  ten_mid = '0;
   logic [4:0]  ten_ttype = '0;
   logic        ten_ack = 1'b0;
   logic [15:0] timeout_cycles = '0;
   logic        host_wr = 1'b0;
   logic [1:0]  host_wdata = '0;
   logic        force_aend, force_dstart, xfer_err;
   logic        err_timeout, err_rsv_type, err_irq;
   logic [3:0]  err_mid;
   logic [4:0]  err_ttype;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 0;
   exp_t q[$];

   addr_tenure_watchdog u0 (
      .clk(clk), .rst_n(rst_n), .ten_start(ten_start), .ten_mid(ten_mid),
      .ten_ttype(ten_ttype), .ten_ack(ten_ack), .timeout_cycles(timeout_cycles),
      .host_wr(host_wr), .host_wdata(host_wdata), .force_aend(force_aend),
      .force_dstart(force_dstart), .xfer_err(xfer_err), .err_timeout(err_timeout),
      .err_rsv_type(err_rsv_type), .err_mid(err_mid), .err_ttype(err_ttype),
      .err_irq(err_irq)
   );

   always #10 clk = ~clk;

   // monitor: one expected pulse triple per driven cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         n_chk++;
         if ({force_aend, force_dstart, xfer_err} !== it.exp) begin
            n_err++;
            $display("FAIL %s pulses actual=%b expected=%b", it.tag,
                     {force_aend, force_dstart, xfer_err}, it.exp);
         end
      end
   end

   task automatic step(input bit s, input logic [3:0] m, input logic [4:0] t,
                       input bit a, input logic [15:0] p, input logic [2:0] e,
                       input string tag);
      exp_t it;
      ten_start = s; ten_mid = m; ten_ttype = t; ten_ack = a; timeout_cycles = p;
      it.exp = e; it.tag = tag;
      q.push_back(it);
      @(posedge clk); #1;
      ten_start = 1'b0; ten_ack = 1'b0;
   endtask

   // ack_at = 0 means no acknowledge at all
   task automatic tenure(input logic [3:0] m, input logic [4:0] t, input int p,
                         input int ack_at, input string tag);
      step(1, m, t, 0, 16'(p), 3'b000, tag);
      for (int c = 1; c <= p; c++) step(0, m, t, (c == ack_at), 16'(p), 3'b000, tag);
      if (ack_at == 0) begin
         step(0, m, t, 0, 16'(p), 3'b100, tag);
         step(0, m, t, 0, 16'(p), 3'b010, tag);
         step(0, m, t, 0, 16'(p), 3'b001, tag);
      end
      step(0, m, t, 0, 16'(p), 3'b000, tag);
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic host_clear(input logic [1:0] bits);
      host_wr = 1'b1; host_wdata = bits;
      @(posedge clk); #1;
      host_wr = 1'b0; host_wdata = '0;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pulses", 16'({force_aend, force_dstart, xfer_err}), 16'h0);
      chk("R1 sticky", 16'({err_timeout, err_rsv_type, err_irq}), 16'h0);
      @(posedge clk); #1;

      tenure(4'd3, 5'd5, 4, 2, "R3 early ack");
      tenure(4'd3, 5'd5, 4, 4, "R3 ack in last cycle");
      @(negedge clk);
      chk("R3 no error", 16'(err_timeout), 16'h0);
      @(posedge clk); #1;

      tenure(4'd6, 5'd5, 4, 0, "R2 R4 timeout P=4");
      @(negedge clk);
      chk("R7 timeout flag", 16'(err_timeout), 16'h1);
      chk("R9 mid captured", 16'(err_mid), 16'h6);
      chk("R9 ttype captured", 16'(err_ttype), 16'h5);
      chk("R10 irq", 16'(err_irq), 16'h1);
      @(posedge clk); #1;

      tenure(4'd9, 5'd7, 2, 0, "R2 R4 timeout P=2");
      @(negedge clk);
      chk("R9 mid held", 16'(err_mid), 16'h6);
      chk("R9 ttype held", 16'(err_ttype), 16'h5);
      @(posedge clk); #1;

      host_clear(2'b10);
      @(negedge clk);
      chk("R7 other bit keeps flag", 16'(err_timeout), 16'h1);
      @(posedge clk); #1;
      host_clear(2'b01);
      @(negedge clk);
      chk("R7 cleared", 16'(err_timeout), 16'h0);
      chk("R10 irq low", 16'(err_irq), 16'h0);
      @(posedge clk); #1;

      step(1, 4'd2, 5'd5, 0, 16'd0, 3'b000, "R5 zero period");
      for (int c = 0; c < 8; c++) step(0, 4'd2, 5'd5, 0, 16'd0, 3'b000, "R5 zero period");
      @(negedge clk);
      chk("R5 no flag", 16'(err_timeout), 16'h0);
      @(posedge clk); #1;

      // R6: restart at cycle 2 with P=5 -> pulses in cycles 8..10
      step(1, 4'd1, 5'd5, 0, 16'd3, 3'b000, "R6 restart");
      step(0, 4'd1, 5'd5, 0, 16'd3, 3'b000, "R6 restart");
      step(1, 4'd12, 5'd4, 0, 16'd5, 3'b000, "R6 restart");
      for (int c = 3; c <= 7; c++) step(0, 4'd12, 5'd4, 0, 16'd5, 3'b000, "R6 restart");
      step(0, 4'd12, 5'd4, 0, 16'd5, 3'b100, "R6 restart");
      step(0, 4'd12, 5'd4, 0, 16'd5, 3'b010, "R6 restart");
      step(0, 4'd12, 5'd4, 0, 16'd5, 3'b001, "R6 restart");
      step(0, 4'd12, 5'd4, 0, 16'd5, 3'b000, "R6 restart");
      @(negedge clk);
      chk("R6 mid of restarted tenure", 16'(err_mid), 16'hC);
      @(posedge clk); #1;
      host_clear(2'b01);

      // R11: P=1 timeout, start offered in cycle 3 (substitute data tenure)
      step(1, 4'd4, 5'd5, 0, 16'd1, 3'b000, "R11 start ignored");
      step(0, 4'd4, 5'd5, 0, 16'd1, 3'b000, "R11 start ignored");
      step(0, 4'd4, 5'd5, 0, 16'd1, 3'b100, "R11 start ignored");
      step(1, 4'd4, 5'd5, 0, 16'd1, 3'b010, "R11 start ignored");
      step(0, 4'd4, 5'd5, 0, 16'd1, 3'b001, "R11 start ignored");
      for (int c = 5; c <= 8; c++) step(0, 4'd4, 5'd5, 0, 16'd1, 3'b000, "R11 start ignored");
      host_clear(2'b01);

      // R8: reserved code 30, period 0
      step(1, 4'd11, 5'd30, 0, 16'd0, 3'b000, "R8 reserved");
      step(0, 4'd0, 5'd5, 0, 16'd0, 3'b100, "R8 reserved");
      step(0, 4'd0, 5'd5, 0, 16'd0, 3'b010, "R8 reserved");
      step(0, 4'd0, 5'd5, 0, 16'd0, 3'b001, "R8 reserved");
      step(0, 4'd0, 5'd5, 0, 16'd0, 3'b000, "R8 reserved");
      @(negedge clk);
      chk("R8 rsv flag", 16'(err_rsv_type), 16'h1);
      chk("R8 timeout flag stays low", 16'(err_timeout), 16'h0);
      chk("R9 rsv mid", 16'(err_mid), 16'hB);
      chk("R9 rsv ttype", 16'(err_ttype), 16'h1E);
      chk("R10 irq from rsv", 16'(err_irq), 16'h1);
      @(posedge clk); #1;
      host_clear(2'b01);
      @(negedge clk);
      chk("R8 wrong bit keeps rsv flag", 16'(err_rsv_type), 16'h1);
      @(posedge clk); #1;
      host_clear(2'b10);
      @(negedge clk);
      chk("R8 rsv cleared", 16'(err_rsv_type), 16'h0);
      @(posedge clk); #1;

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule